// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits between a launch queue and a group of multiprocessors. Each request on its input channel describes one thread block: how many threads it has and how many registers each thread needs. The controller keeps a running ledger per multiprocessor of resident blocks, resident threads and allocated registers. It places each block whole on a single multiprocessor, and only where the block-slot limit, the thread limit and the register limit all still hold after the placement.

Requests are served strictly in arrival order. The scan for a home starts at the multiprocessor after the one that received the last grant and takes the first candidate that fits. When the head request fits nowhere, the input channel applies back-pressure until completions free enough resources. A completion carries the multiprocessor index and the finished block's thread and register-per-thread figures. Its release takes effect in the same cycle, and a request waiting in that cycle is judged against the freed totals.

Input channel rules: a request transfers on a rising clock edge with `req_valid` and `req_ready` both high. `req_ready` is combinational from the request fields, the completion inputs and the ledgers. A source holding a request that did not fit keeps it presented unchanged. The controller never skips past it to a later request. Grants and errors are single-cycle pulses with no back-pressure.

Top module: `blk_admit`

## Requirements
- R1: A multiprocessor never holds more than 8 resident blocks. A ninth block waits, even when threads and registers would allow it.
- R2: The threads resident on one multiprocessor never exceed 768 in total. A block that would bring the total to exactly 768 is admitted, and one that would reach 769 waits.
- R3: A block consumes threads × registers-per-thread from a per-multiprocessor pool of 8192 registers, and is admitted only if the remaining pool covers it. With 256 threads at 10 registers, three such blocks share one multiprocessor. At 11 registers only two do.
- R4: A request with a thread count of 0 or above 512 is accepted at once (`req_ready` high). It pulses `req_err` for one cycle in the cycle after the transfer, produces no grant, and changes neither the ledgers nor the scan start point. A request with 512 threads is valid.
- R5: Every accepted valid request produces exactly one `gnt_valid` pulse in the cycle after the transfer, with `gnt_sm` holding the chosen multiprocessor index, from 0 to 3. No grant appears without a transfer.
- R6: The scan begins at the multiprocessor after the most recently granted one, wrapping from 3 to 0, and picks the first that fits. After reset the first scan begins at multiprocessor 0.
- R7: When no multiprocessor fits the head request, `req_ready` is low and no grant or error is produced. The request stays at the head.
- R8: A completion pulse (`cpl_valid`) releases one block, `cpl_thr` threads and `cpl_thr`×`cpl_rpt` registers from multiprocessor `cpl_sm`. The release is applied before the fit check of the same cycle, so a stalled request that fits after the release is accepted in that same cycle.
- R9: After reset all ledgers are empty, and `gnt_valid` and `req_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request can transfer this cycle |
| req_thr | input | 10 | Threads in the requested block |
| req_rpt | input | 8 | Registers per thread of the requested block |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_sm | output | 2 | Multiprocessor receiving the grant |
| req_err | output | 1 | One-cycle pulse: thread count out of range |
| cpl_valid | input | 1 | One-cycle completion pulse |
| cpl_sm | input | 2 | Multiprocessor where the block finished |
| cpl_thr | input | 10 | Threads of the finished block |
| cpl_rpt | input | 8 | Registers per thread of the finished block |

## Verification
A ledger that holds the wrong value is not visible directly. It shows up as a grant to the wrong multiprocessor, or as `req_ready` in the wrong state, the first time a request lands on a capacity boundary. The tests therefore drive each limit exactly to its edge and check both the last admitted request and the first refused one. A wrong scan pointer shows up in the very next grant index. A release that is applied late shows up as `req_ready` staying low for one extra cycle in the same cycle as the completion.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  // Index reached by stepping forward from a base, wrapping over n entries.
  function automatic int unsigned wrap_step(int unsigned base, int unsigned step,
                                            int unsigned n);
    return (base + step) % n;
  endfunction

  // Bits needed to hold the values 0..v.
  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/sm_ledger.sv
module sm_ledger #(
  parameter int unsigned MAX_BLK  = 8,
  parameter int unsigned MAX_THR  = 768,
  parameter int unsigned REG_POOL = 8192,
  parameter int unsigned BLK_W    = 4,
  parameter int unsigned THR_W    = 10,
  parameter int unsigned REG_W    = 14,
  parameter int unsigned RT_W     = 10,
  parameter int unsigned PROD_W   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              give_back,
  input  logic [RT_W-1:0]   take_thr,
  input  logic [PROD_W-1:0] take_regs,
  input  logic [RT_W-1:0]   back_thr,
  input  logic [PROD_W-1:0] back_regs,
  output logic              fits,
  output logic [BLK_W-1:0]  blk_q,
  output logic [THR_W-1:0]  thr_q,
  output logic [REG_W-1:0]  reg_q
);
  logic [31:0] blk_rel, thr_rel, reg_rel;

  // Totals after this cycle's release; the fit check uses these.
  always_comb begin
    blk_rel = 32'(blk_q) - (give_back ? 32'd1 : 32'd0);
    thr_rel = 32'(thr_q) - (give_back ? 32'(back_thr) : 32'd0);
    reg_rel = 32'(reg_q) - (give_back ? 32'(back_regs) : 32'd0);
    fits = (blk_rel < 32'(MAX_BLK)) &&
           (thr_rel + 32'(take_thr) <= 32'(MAX_THR)) &&
           (reg_rel + 32'(take_regs) <= 32'(REG_POOL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      thr_q <= '0;
      reg_q <= '0;
    end else begin
      blk_q <= BLK_W'(blk_rel + (take ? 32'd1 : 32'd0));
      thr_q <= THR_W'(thr_rel + (take ? 32'(take_thr) : 32'd0));
      reg_q <= REG_W'(reg_rel + (take ? 32'(take_regs) : 32'd0));
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  fits,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  import blk_admit_pkg::*;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int unsigned s = 1; s <= N; s++) begin
      int unsigned idx;
      idx = wrap_step(32'(last), s, N);
      if (!found && fits[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/blk_admit.sv
module blk_admit #(
  parameter int unsigned NUM_SM      = 4,
  parameter int unsigned MAX_BLK     = 8,
  parameter int unsigned MAX_THR     = 768,
  parameter int unsigned REG_POOL    = 8192,
  parameter int unsigned MAX_REQ_THR = 512,
  parameter int unsigned RPT_W       = 8,
  localparam int unsigned SM_W   = blk_admit_pkg::bits_for(NUM_SM - 1),
  localparam int unsigned RT_W   = blk_admit_pkg::bits_for(MAX_REQ_THR),
  localparam int unsigned BLK_W  = blk_admit_pkg::bits_for(MAX_BLK),
  localparam int unsigned THR_W  = blk_admit_pkg::bits_for(MAX_THR),
  localparam int unsigned REG_W  = blk_admit_pkg::bits_for(REG_POOL),
  localparam int unsigned PROD_W = RT_W + RPT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [RT_W-1:0]  req_thr,
  input  logic [RPT_W-1:0] req_rpt,
  output logic             gnt_valid,
  output logic [SM_W-1:0]  gnt_sm,
  output logic             req_err,
  input  logic             cpl_valid,
  input  logic [SM_W-1:0]  cpl_sm,
  input  logic [RT_W-1:0]  cpl_thr,
  input  logic [RPT_W-1:0] cpl_rpt
);
  logic [PROD_W-1:0] req_regs, cpl_regs;
  logic              thr_ok, found, accept_ok, hs;
  logic [SM_W-1:0]   pick, last_q;
  logic [NUM_SM-1:0] fits, take, give;
  logic [NUM_SM-1:0][BLK_W-1:0] occ_blk;
  logic [NUM_SM-1:0][THR_W-1:0] occ_thr;
  logic [NUM_SM-1:0][REG_W-1:0] occ_reg;

  assign req_regs  = PROD_W'(req_thr) * PROD_W'(req_rpt);
  assign cpl_regs  = PROD_W'(cpl_thr) * PROD_W'(cpl_rpt);
  assign thr_ok    = (req_thr != '0) && (32'(req_thr) <= MAX_REQ_THR);
  assign req_ready = !thr_ok || found;
  assign hs        = req_valid && req_ready;
  assign accept_ok = hs && thr_ok;

  for (genvar i = 0; i < NUM_SM; i++) begin : g_sm
    assign take[i] = accept_ok && (pick == SM_W'(i));
    assign give[i] = cpl_valid && (cpl_sm == SM_W'(i));

    sm_ledger #(
      .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .REG_POOL(REG_POOL),
      .BLK_W(BLK_W), .THR_W(THR_W), .REG_W(REG_W),
      .RT_W(RT_W), .PROD_W(PROD_W)
    ) u_ledger (
      .clk(clk), .rst_n(rst_n),
      .take(take[i]), .give_back(give[i]),
      .take_thr(req_thr), .take_regs(req_regs),
      .back_thr(cpl_thr), .back_regs(cpl_regs),
      .fits(fits[i]),
      .blk_q(occ_blk[i]), .thr_q(occ_thr[i]), .reg_q(occ_reg[i])
    );
  end

  rr_pick #(.N(NUM_SM), .IW(SM_W)) u_pick (
    .fits(fits), .last(last_q), .found(found), .pick(pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_sm    <= '0;
      req_err   <= 1'b0;
      last_q    <= SM_W'(NUM_SM - 1);
    end else begin
      gnt_valid <= accept_ok;
      req_err   <= hs && !thr_ok;
      if (accept_ok) begin
        gnt_sm <= pick;
        last_q <= pick;
      end
    end
  end
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int unsigned NUM_SM      = 4,
  parameter int unsigned MAX_BLK     = 8,
  parameter int unsigned MAX_THR     = 768,
  parameter int unsigned REG_POOL    = 8192,
  parameter int unsigned MAX_REQ_THR = 512,
  parameter int unsigned SM_W  = 2,
  parameter int unsigned RT_W  = 10,
  parameter int unsigned BLK_W = 4,
  parameter int unsigned THR_W = 10,
  parameter int unsigned REG_W = 14
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic [RT_W-1:0] req_thr,
  input logic gnt_valid,
  input logic [SM_W-1:0] gnt_sm,
  input logic req_err,
  input logic [NUM_SM-1:0][BLK_W-1:0] occ_blk,
  input logic [NUM_SM-1:0][THR_W-1:0] occ_thr,
  input logic [NUM_SM-1:0][REG_W-1:0] occ_reg
);
  logic bad_thr;
  assign bad_thr = (req_thr == '0) || (32'(req_thr) > MAX_REQ_THR);

  for (genvar i = 0; i < NUM_SM; i++) begin : g_cap
    p_blk_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ_blk[i]) <= MAX_BLK);
    p_thr_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ_thr[i]) <= MAX_THR);
    p_reg_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ_reg[i]) <= REG_POOL);
  end

  p_bad_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_thr) |-> req_ready);
  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && req_ready && bad_thr));
  p_gnt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $past(req_valid && req_ready && !bad_thr));
  p_gnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (32'(gnt_sm) < NUM_SM));
  p_no_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && req_err));
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!gnt_valid && !req_err));
endmodule

bind blk_admit blk_admit_chk #(
  .NUM_SM(NUM_SM), .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .REG_POOL(REG_POOL),
  .MAX_REQ_THR(MAX_REQ_THR), .SM_W(SM_W), .RT_W(RT_W), .BLK_W(BLK_W),
  .THR_W(THR_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_thr(req_thr), .gnt_valid(gnt_valid), .gnt_sm(gnt_sm),
  .req_err(req_err), .occ_blk(occ_blk), .occ_thr(occ_thr), .occ_reg(occ_reg)
);

// File: tb/blk_admit_test.sv
`timescale 1ns/1ps
module blk_admit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [9:0] req_thr = '0;
  logic [7:0] req_rpt = '0;
  logic       gnt_valid;
  logic [1:0] gnt_sm;
  logic       req_err;
  logic       cpl_valid = 1'b0;
  logic [1:0] cpl_sm = '0;
  logic [9:0] cpl_thr = '0;
  logic [7:0] cpl_rpt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blk_admit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_thr(req_thr), .req_rpt(req_rpt), .gnt_valid(gnt_valid),
    .gnt_sm(gnt_sm), .req_err(req_err), .cpl_valid(cpl_valid),
    .cpl_sm(cpl_sm), .cpl_thr(cpl_thr), .cpl_rpt(cpl_rpt)
  );

  typedef struct packed {
    logic [9:0] thr;
    logic [7:0] rpt;
    logic       err;
    logic [1:0] sm;
  } vec_t;

  // Fill every multiprocessor with three 256x10 blocks, then two bad sizes.
  localparam vec_t VECS [14] = '{
    '{10'd256, 8'd10, 1'b0, 2'd0}, '{10'd256, 8'd10, 1'b0, 2'd1},
    '{10'd256, 8'd10, 1'b0, 2'd2}, '{10'd256, 8'd10, 1'b0, 2'd3},
    '{10'd256, 8'd10, 1'b0, 2'd0}, '{10'd256, 8'd10, 1'b0, 2'd1},
    '{10'd256, 8'd10, 1'b0, 2'd2}, '{10'd256, 8'd10, 1'b0, 2'd3},
    '{10'd256, 8'd10, 1'b0, 2'd0}, '{10'd256, 8'd10, 1'b0, 2'd1},
    '{10'd256, 8'd10, 1'b0, 2'd2}, '{10'd256, 8'd10, 1'b0, 2'd3},
    '{10'd0,   8'd4,  1'b1, 2'd0}, '{10'd513, 8'd1,  1'b1, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    cpl_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present one request that is expected to transfer at the next edge.
  task automatic send(input int thr, input int rpt, input bit exp_err,
                      input int exp_sm, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_thr = 10'(thr);
    req_rpt = 8'(rpt);
    #1;
    check(req_ready == 1'b1, {req, " ready"}, int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(gnt_valid == !exp_err, {req, " grant"}, int'(gnt_valid), int'(!exp_err));
    check(req_err == exp_err, {req, " err"}, int'(req_err), int'(exp_err));
    if (!exp_err)
      check(int'(gnt_sm) == exp_sm, {req, " sm"}, int'(gnt_sm), exp_sm);
  endtask

  // Present a request that must not fit; check two cycles of stall.
  task automatic hold_stalled(input int thr, input int rpt, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_thr = 10'(thr);
    req_rpt = 8'(rpt);
    for (int k = 0; k < 2; k++) begin
      #1;
      check(req_ready == 1'b0, {req, " stall ready (R7)"}, int'(req_ready), 0);
      @(negedge clk);
      check(gnt_valid == 1'b0 && req_err == 1'b0, {req, " stall quiet (R7)"},
            int'(gnt_valid), 0);
    end
  endtask

  // With a stalled request held, complete a block and expect same-cycle accept.
  task automatic release_and_take(input int sm, input int thr, input int rpt,
                                  input int exp_sm, input string req);
    cpl_valid = 1'b1;
    cpl_sm = 2'(sm);
    cpl_thr = 10'(thr);
    cpl_rpt = 8'(rpt);
    #1;
    check(req_ready == 1'b1, {req, " ready with release (R8)"}, int'(req_ready), 1);
    @(negedge clk);
    cpl_valid = 1'b0;
    req_valid = 1'b0;
    check(gnt_valid == 1'b1, {req, " grant after release (R8)"}, int'(gnt_valid), 1);
    check(int'(gnt_sm) == exp_sm, {req, " sm after release (R6)"}, int'(gnt_sm), exp_sm);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: reset state
    @(negedge clk);
    check(gnt_valid == 1'b0, "R9 gnt_valid after reset", int'(gnt_valid), 0);
    check(req_err == 1'b0, "R9 req_err after reset", int'(req_err), 0);

    // Table: R3 (256x10 three per SM), R5, R6 rotation, R4 bad sizes
    foreach (VECS[i]) begin
      send(int'(VECS[i].thr), int'(VECS[i].rpt), VECS[i].err, int'(VECS[i].sm),
           $sformatf("R3/R4/R5/R6 vec%0d", i));
    end
    // All full: stall, then release on SM 2 and take it the same cycle.
    hold_stalled(256, 10, "R7 full");
    release_and_take(2, 256, 10, 2, "R8 sm2");

    // R3: 256x11 fits only twice per SM
    do_reset();
    for (int i = 0; i < 8; i++) send(256, 11, 1'b0, i % 4, "R3 rpt11");
    hold_stalled(256, 11, "R3 third rpt11");
    @(negedge clk);
    req_valid = 1'b0;

    // R1: eight blocks per SM
    do_reset();
    for (int i = 0; i < 32; i++) send(32, 1, 1'b0, i % 4, "R1 fill");
    hold_stalled(32, 1, "R1 ninth block");
    release_and_take(1, 32, 1, 1, "R1 sm1");

    // R2 and R4 boundaries; a reject leaves the scan start at SM 0 (R6)
    do_reset();
    send(0, 5, 1'b1, 0, "R4 zero threads");
    for (int i = 0; i < 4; i++) send(512, 1, 1'b0, i, "R4/R6 512 threads");
    hold_stalled(257, 1, "R2 769 threads");
    @(negedge clk);
    req_valid = 1'b0;
    send(256, 1, 1'b0, 0, "R2 exactly 768");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule